// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by counting ticks of a slow low-power reference. The reference is present as a single-cycle enable input in the system clock domain. Software must strobe the clear input before the selected timeout runs out. If it does not, the block raises a one-cycle reset request and starts counting again. When the window option is on, every count starts with a closed stretch followed by an open stretch. A clear that arrives while the window is closed is treated as a fault and also raises a reset request. A clear in the open stretch restarts the closed stretch.

Configuration goes through one small write port with three addresses. The key address unlocks the two protected registers for a short time. The control register holds the run enable and the timeout code. The window register holds the window enable and the closed-stretch code. An enable bit changes only if the same write also sets its change-enable bit. An accepted write is held until the next reference tick, and a busy flag is high while it waits. A lock input models a configuration fuse: while it is high, the protected registers cannot be written. Read-back buses show the active settings.

Top module: `guard_wdt`

## Requirements
- R1: After synchronous reset, `rst_req_o` and `busy_o` are 0, both read-back buses are 0, and the watchdog is stopped with window mode off.
- R2: A write of 8'h5A to address 0 opens protected access for exactly the four following cycles. A write to address 1 (control) or address 2 (window) outside those four cycles is ignored. Any other value written to address 0 closes access at once.
- R3: In both protected registers, bit 0 is the change-enable bit, bit 1 is the enable bit and bits 5:2 are the period code. An accepted write updates the code in every case, but updates the enable bit only when bit 0 of the same write is 1. Read-back has the same layout, with bit 0 and bits 7:6 reading as 0.
- R4: A write whose code field holds 11 to 15 is ignored entirely and does not raise `busy_o`.
- R5: While `fuse_lock_i` is 1, writes to the protected registers are ignored.
- R6: An accepted write raises `busy_o` on the next cycle. `busy_o` stays high until the first tick after that. On that tick the new value becomes active and appears on read-back, and `busy_o` falls in the same cycle. Protected writes are ignored while `busy_o` is high.
- R7: With window mode off, the counter advances by one on each tick. When the count reaches 8 << code ticks with no clear, `rst_req_o` goes high in the cycle after the completing tick.
- R8: With window mode off, each clear restarts the count from zero and raises no reset request.
- R9: With window mode on, the closed stretch lasts 8 << window-code ticks and the open stretch lasts 8 << code ticks. A clear during the closed stretch raises `rst_req_o` in the next cycle.
- R10: A clear during the open stretch raises no request and restarts the closed stretch from zero.
- R11: A clear in the same cycle as the tick that would complete the count wins: no request is raised.
- R12: While the run enable is 0, no reset request is raised and the count stays at zero.
- R13: A reset request lasts one cycle, and after it the count restarts from zero in the closed stretch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle enable from the slow reference |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 key, 1 control, 2 window |
| wr_data_i | input | 8 | Write data |
| kick_i | input | 1 | Clear strobe from software |
| fuse_lock_i | input | 1 | Configuration lock |
| busy_o | output | 1 | A write is waiting for the next tick |
| rst_req_o | output | 1 | One-cycle system reset request |
| ctrl_rd_o | output | 8 | Active control settings |
| win_rd_o | output | 8 | Active window settings |

## Verification
The hard coincidence is a clear that lands on the very tick that would complete the count. In that cycle the expiry and the restart compete. The bench watches its own model count and drives the clear exactly on the expiring tick, then expects no request in the next cycle. A second coincidence is a write accepted while the tick that applies a previous write arrives. The busy gate must reject the second write. The bench checks this by writing again while busy is high and then confirming that only the first value reaches read-back.

// File: rtl/guard_wdt_pkg.sv
package guard_wdt_pkg;
  localparam int CODE_W = 4;
  localparam logic [1:0] ADDR_KEY  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_WIN  = 2'd2;
  localparam int FLD_CHG  = 0;
  localparam int FLD_EN   = 1;
  localparam int FLD_CODE = 2;

  typedef enum logic {PH_CLOSED = 1'b0, PH_OPEN = 1'b1} phase_e;

  typedef struct packed {
    logic              sel_win;
    logic              chg;
    logic              en;
    logic [CODE_W-1:0] code;
  } stage_t;
endpackage

// File: rtl/guard_wdt_span.sv
module guard_wdt_span
  import guard_wdt_pkg::*;
#(
  parameter int CNT_W      = 14,
  parameter int BASE_SHIFT = 3
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  span_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  always_comb begin
    span_o = ONE << (BASE_SHIFT + int'(code_i));
  end
endmodule

// File: rtl/guard_wdt_cfg.sv
module guard_wdt_cfg
  import guard_wdt_pkg::*;
#(
  parameter int               DATA_W     = 8,
  parameter int               MAX_CODE   = 10,
  parameter logic [DATA_W-1:0] KEY       = 'h5A,
  parameter int               UNLOCK_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              lock_i,
  output logic              run_en_o,
  output logic              win_en_o,
  output logic [CODE_W-1:0] per_o,
  output logic [CODE_W-1:0] wper_o,
  output logic              busy_o
);
  localparam int KW = $clog2(UNLOCK_CYC + 1);
  localparam logic [KW-1:0] KEY_LOAD = KW'(UNLOCK_CYC);

  logic [KW-1:0]     key_q;
  logic              pend_q;
  stage_t            stg_q;
  logic              run_q, win_q;
  logic [CODE_W-1:0] per_q, wper_q;
  logic [CODE_W-1:0] wcode;
  logic              key_hit, prot_hit, code_ok, accept;

  assign wcode = wr_data_i[FLD_CODE +: CODE_W];

  always_comb begin
    key_hit  = wr_en_i && (wr_addr_i == ADDR_KEY);
    prot_hit = wr_en_i && ((wr_addr_i == ADDR_CTRL) || (wr_addr_i == ADDR_WIN));
    code_ok  = (wcode <= CODE_W'(MAX_CODE));
    accept   = prot_hit && (key_q != '0) && !pend_q && !lock_i && code_ok;
  end

  // unlock window after the key write
  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
    end else if (key_hit) begin
      key_q <= (wr_data_i == KEY) ? KEY_LOAD : '0;
    end else if (key_q != '0) begin
      key_q <= key_q - 1'b1;
    end
  end

  // staging and transfer into the tick domain
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      stg_q  <= '0;
      run_q  <= 1'b0;
      win_q  <= 1'b0;
      per_q  <= '0;
      wper_q <= '0;
    end else if (pend_q && tick_i) begin
      pend_q <= 1'b0;
      if (stg_q.sel_win) begin
        wper_q <= stg_q.code;
        if (stg_q.chg) win_q <= stg_q.en;
      end else begin
        per_q <= stg_q.code;
        if (stg_q.chg) run_q <= stg_q.en;
      end
    end else if (accept) begin
      pend_q        <= 1'b1;
      stg_q.sel_win <= (wr_addr_i == ADDR_WIN);
      stg_q.chg     <= wr_data_i[FLD_CHG];
      stg_q.en      <= wr_data_i[FLD_EN];
      stg_q.code    <= wcode;
    end
  end

  assign run_en_o = run_q;
  assign win_en_o = win_q;
  assign per_o    = per_q;
  assign wper_o   = wper_q;
  assign busy_o   = pend_q;
endmodule

// File: rtl/guard_wdt_counter.sv
module guard_wdt_counter
  import guard_wdt_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             run_en_i,
  input  logic             win_en_i,
  input  logic [CNT_W-1:0] closed_span_i,
  input  logic [CNT_W-1:0] open_span_i,
  output logic             rst_req_o,
  output logic             in_open_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nx;
  phase_e           ph_q;
  logic             req_q;
  logic             closed_now, closed_done, open_done;

  always_comb begin
    cnt_nx      = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    closed_now  = win_en_i && (ph_q == PH_CLOSED);
    closed_done = cnt_nx >= {1'b0, closed_span_i};
    open_done   = cnt_nx >= {1'b0, open_span_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ph_q  <= PH_CLOSED;
      req_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (!run_en_i) begin
        cnt_q <= '0;
        ph_q  <= PH_CLOSED;
      end else if (kick_i) begin
        cnt_q <= '0;
        ph_q  <= PH_CLOSED;
        if (closed_now) req_q <= 1'b1;
      end else if (tick_i) begin
        if (closed_now) begin
          if (closed_done) begin
            cnt_q <= '0;
            ph_q  <= PH_OPEN;
          end else begin
            cnt_q <= cnt_nx[CNT_W-1:0];
          end
        end else if (open_done) begin
          cnt_q <= '0;
          ph_q  <= PH_CLOSED;
          req_q <= 1'b1;
        end else begin
          cnt_q <= cnt_nx[CNT_W-1:0];
        end
      end
    end
  end

  assign rst_req_o = req_q;
  assign in_open_o = (ph_q == PH_OPEN);
endmodule

// File: rtl/guard_wdt.sv
module guard_wdt
  import guard_wdt_pkg::*;
#(
  parameter int               CNT_W      = 14,
  parameter int               BASE_SHIFT = 3,
  parameter int               MAX_CODE   = 10,
  parameter int               DATA_W     = 8,
  parameter logic [DATA_W-1:0] KEY       = 'h5A,
  parameter int               UNLOCK_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              kick_i,
  input  logic              fuse_lock_i,
  output logic              busy_o,
  output logic              rst_req_o,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic [DATA_W-1:0] win_rd_o
);
  logic              run_en, win_en, in_open;
  logic [CODE_W-1:0] per, wper;
  logic [CNT_W-1:0]  open_span, closed_span;

  guard_wdt_cfg #(
    .DATA_W(DATA_W), .MAX_CODE(MAX_CODE), .KEY(KEY), .UNLOCK_CYC(UNLOCK_CYC)
  ) u_cfg (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .lock_i(fuse_lock_i),
    .run_en_o(run_en), .win_en_o(win_en), .per_o(per), .wper_o(wper),
    .busy_o(busy_o)
  );

  guard_wdt_span #(.CNT_W(CNT_W), .BASE_SHIFT(BASE_SHIFT)) u_open_span (
    .code_i(per), .span_o(open_span)
  );

  guard_wdt_span #(.CNT_W(CNT_W), .BASE_SHIFT(BASE_SHIFT)) u_closed_span (
    .code_i(wper), .span_o(closed_span)
  );

  guard_wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i), .kick_i(kick_i),
    .run_en_i(run_en), .win_en_i(win_en),
    .closed_span_i(closed_span), .open_span_i(open_span),
    .rst_req_o(rst_req_o), .in_open_o(in_open)
  );

  assign ctrl_rd_o = DATA_W'({per, run_en, 1'b0});
  assign win_rd_o  = DATA_W'({wper, win_en, 1'b0});
endmodule

// File: rtl/guard_wdt_chk.sv
module guard_wdt_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_i,
  input logic       kick_i,
  input logic       fuse_lock_i,
  input logic       busy_o,
  input logic       rst_req_o,
  input logic       run_en,
  input logic       win_en,
  input logic       in_open,
  input logic [7:0] ctrl_rd_o,
  input logic [7:0] win_rd_o
);
  a_r12_stopped_quiet: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> !rst_req_o);

  a_r9_early_clear: assert property (@(posedge clk) disable iff (rst)
    (run_en && win_en && !in_open && kick_i) |=> rst_req_o);

  a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (run_en && kick_i && !(win_en && !in_open)) |=> !rst_req_o);

  a_r6_readback_hold: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && tick_i) |=> ($stable(ctrl_rd_o) && $stable(win_rd_o)));

  a_r6_busy_release: assert property (@(posedge clk) disable iff (rst)
    (busy_o && tick_i) |=> !busy_o);

  a_r5_lock_blocks: assert property (@(posedge clk) disable iff (rst)
    (fuse_lock_i && !busy_o) |=> !busy_o);
endmodule

bind guard_wdt guard_wdt_chk u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .kick_i(kick_i),
  .fuse_lock_i(fuse_lock_i), .busy_o(busy_o), .rst_req_o(rst_req_o),
  .run_en(run_en), .win_en(win_en), .in_open(in_open),
  .ctrl_rd_o(ctrl_rd_o), .win_rd_o(win_rd_o)
);

// File: tb/guard_wdt_tb.sv
`timescale 1ns/1ps
module guard_wdt_tb;
  localparam logic [7:0] KEY = 8'h5A;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0, wr_en_i = 1'b0, kick_i = 1'b0, fuse_lock_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic       busy_o, rst_req_o;
  logic [7:0] ctrl_rd_o, win_rd_o;

  int checks = 0, errors = 0, tph = 0, cyc_n = 0;
  bit cmp_on = 0, done = 0;
  string cur_req = "R1";

  // reference model state
  bit       m_en, m_win, m_open, m_req, m_pend, m_psel, m_pchg, m_pen;
  bit [3:0] m_per, m_wper, m_pcode;
  int       m_cnt, m_key, lim_c, lim_o;

  always #2.5 clk = ~clk;

  guard_wdt u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .kick_i(kick_i),
    .fuse_lock_i(fuse_lock_i), .busy_o(busy_o), .rst_req_o(rst_req_o),
    .ctrl_rd_o(ctrl_rd_o), .win_rd_o(win_rd_o)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_win = 0; m_open = 0; m_req = 0; m_pend = 0;
      m_per = 0; m_wper = 0; m_cnt = 0; m_key = 0;
    end else begin
      lim_c = 8 << m_wper;
      lim_o = 8 << m_per;
      m_req = 0;
      if (!m_en) begin
        m_cnt = 0; m_open = 0;
      end else if (kick_i) begin
        if (m_win && !m_open) m_req = 1;
        m_cnt = 0; m_open = 0;
      end else if (tick_i) begin
        if (m_win && !m_open) begin
          if (m_cnt + 1 >= lim_c) begin m_cnt = 0; m_open = 1; end
          else m_cnt = m_cnt + 1;
        end else if (m_cnt + 1 >= lim_o) begin
          m_cnt = 0; m_open = 0; m_req = 1;
        end else m_cnt = m_cnt + 1;
      end
      if (m_pend && tick_i) begin
        m_pend = 0;
        if (m_psel) begin m_wper = m_pcode; if (m_pchg) m_win = m_pen; end
        else begin m_per = m_pcode; if (m_pchg) m_en = m_pen; end
      end else if (wr_en_i && (wr_addr_i == 2'd1 || wr_addr_i == 2'd2) && m_key > 0
                   && !m_pend && !fuse_lock_i && wr_data_i[5:2] <= 4'd10) begin
        m_pend = 1; m_psel = (wr_addr_i == 2'd2);
        m_pchg = wr_data_i[0]; m_pen = wr_data_i[1]; m_pcode = wr_data_i[5:2];
      end
      if (wr_en_i && wr_addr_i == 2'd0) m_key = (wr_data_i == KEY) ? 4 : 0;
      else if (m_key > 0) m_key = m_key - 1;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if ({rst_req_o, busy_o, ctrl_rd_o, win_rd_o} !==
          {m_req, m_pend, {2'b00, m_per, m_en, 1'b0}, {2'b00, m_wper, m_win, 1'b0}}) begin
        errors++;
        $display("FAIL %s model: req=%b busy=%b ctrl=%h win=%h expected req=%b busy=%b ctrl=%h win=%h",
                 cur_req, rst_req_o, busy_o, ctrl_rd_o, win_rd_o, m_req, m_pend,
                 {2'b00, m_per, m_en, 1'b0}, {2'b00, m_wper, m_win, 1'b0});
      end
    end
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic cyc(input logic k, input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    tick_i = ((tph % 3) == 2);
    tph++;
    kick_i = k; wr_en_i = w; wr_addr_i = a; wr_data_i = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b1, a, d);
  endtask

  task automatic kick();
    cyc(1'b1, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic wait_apply();
    idle(1);
    for (int i = 0; i < 20; i++) begin
      if (!busy_o) break;
      idle(1);
    end
  endtask

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic count_pulses(input int n, output int p);
    bit prev = 0;
    p = 0;
    for (int i = 0; i < n; i++) begin
      idle(1);
      if (rst_req_o) p++;
      if (prev && rst_req_o) chk("R13", 8'h1, 8'h0); // request longer than one cycle
      prev = rst_req_o;
    end
  endtask

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {6'b0, rst_req_o, busy_o}, 8'h00);
    chk("R1", ctrl_rd_o, 8'h00);
    chk("R1", win_rd_o, 8'h00);
    cmp_on = 1;

    // R2 key gating
    cur_req = "R2";
    wr(2'd1, 8'h07); idle(1);
    chk("R2", {7'b0, busy_o}, 8'h00);
    wr(2'd0, KEY); idle(4); wr(2'd1, 8'h07); idle(1);
    chk("R2", {7'b0, busy_o}, 8'h00);
    wr(2'd0, KEY); wr(2'd0, 8'h11); wr(2'd1, 8'h07); idle(1);
    chk("R2", {7'b0, busy_o}, 8'h00);

    // R3 change-enable: last accepted cycle of the key window, no change bit
    cur_req = "R3";
    wr(2'd0, KEY); idle(3); wr(2'd1, 8'h06); idle(1);
    chk("R2", {7'b0, busy_o}, 8'h01);
    wait_apply();
    chk("R3", ctrl_rd_o, 8'h04);
    wr(2'd0, KEY); wr(2'd1, 8'h03); wait_apply();
    chk("R3", ctrl_rd_o, 8'h02);

    // R4 reserved code
    cur_req = "R4";
    wr(2'd0, KEY); wr(2'd1, 8'h33); idle(1);
    chk("R4", {7'b0, busy_o}, 8'h00);
    idle(3);
    chk("R4", ctrl_rd_o, 8'h02);

    // R5 lock
    cur_req = "R5";
    fuse_lock_i = 1'b1;
    wr(2'd0, KEY); wr(2'd1, 8'h07); idle(1);
    chk("R5", {7'b0, busy_o}, 8'h00);
    idle(3);
    chk("R5", ctrl_rd_o, 8'h02);
    fuse_lock_i = 1'b0;

    // R6 busy gating
    cur_req = "R6";
    wr(2'd0, KEY); wr(2'd1, 8'h07); idle(1);
    chk("R6", {7'b0, busy_o}, 8'h01);
    wr(2'd1, 8'h0B); wait_apply();
    chk("R6", ctrl_rd_o, 8'h06);
    wr(2'd0, KEY); wr(2'd1, 8'h03); wait_apply();
    chk("R6", ctrl_rd_o, 8'h02);

    // R7 / R13 timeout without clears
    cur_req = "R7";
    count_pulses(60, p);
    chk("R7", (p >= 2) ? 8'h1 : 8'h0, 8'h1);

    // R8 regular clears
    cur_req = "R8";
    kick();
    for (int i = 0; i < 6; i++) begin
      count_pulses(12, p);
      chk("R8", p[7:0], 8'h00);
      kick();
    end

    // R9 window on, early clear
    cur_req = "R9";
    wr(2'd0, KEY); wr(2'd2, 8'h03); wait_apply();
    chk("R9", win_rd_o, 8'h02);
    kick(); idle(1);
    chk("R9", {7'b0, rst_req_o}, 8'h01);

    // R10 clears in the open stretch
    cur_req = "R10";
    for (int i = 0; i < 3; i++) begin
      idle(29); kick(); idle(1);
      chk("R10", {7'b0, rst_req_o}, 8'h00);
    end

    // R11 clear on the expiring tick, window off
    cur_req = "R11";
    wr(2'd0, KEY); wr(2'd2, 8'h01); wait_apply();
    for (int i = 0; i < 200; i++) begin
      if (m_cnt == 7 && (tph % 3) == 2) break;
      idle(1);
    end
    kick(); idle(1);
    chk("R11", {7'b0, rst_req_o}, 8'h00);

    // R12 stopped
    cur_req = "R12";
    wr(2'd0, KEY); wr(2'd1, 8'h01); wait_apply();
    chk("R12", ctrl_rd_o, 8'h00);
    count_pulses(80, p);
    chk("R12", p[7:0], 8'h00);

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule